// File: doc/BRIEF.md
# Timed-Access Guarded Watchdog

This block protects a small control register so that ordinary code cannot change it by accident. Software must first write two key bytes, AAh and then 55h, to an unlock register. That opens a short window, counted in machine cycles, and a single write to the guarded register during the window takes effect. Any other write to the guarded register is discarded.

The block also holds a watchdog counter that advances on machine-cycle ticks. After reset the same counter first provides an oscillator start-up delay, and it holds the processor reset output high until that delay ends. While the watchdog is enabled, the counter must be restarted through a guarded write of its restart bit before it reaches the timeout. If it reaches the timeout, the processor reset output pulses for two ticks and a timeout cause flag is set. Reading the status register returns the flag and then clears it.

Register map: unlock register at 3Ah, guarded register at 3Bh, status register at 3Ch. In the guarded register, bit 7 is the restart command, bit 6 enables the watchdog, and bits 5..0 are general protected bits. In the status register, bit 0 is the timeout flag.

Top module: `guarded_wdt`

## Requirements
- R1: While rst_ni is low and just after it is released, cpu_rst_o is 1, prot_o equals 7'h00 and wdt_flag_o is 0.
- R2: After reset, cpu_rst_o stays 1 for exactly START_CYC ticks of tick_i and then drops to 0.
- R3: A write of AAh to address 3Ah followed by a write of 55h to 3Ah opens a window. A write to address 3Bh inside that window loads wr_data_i[6:0] into prot_o.
- R4: The window stays open for WIN (default 4) ticks after the 55h write. A guarded write made after 3 ticks takes effect. A guarded write made after 4 ticks is ignored.
- R5: If the second byte written to 3Ah is anything other than 55h, the sequence is cancelled. A later lone 55h does not open the window.
- R6: A write to 3Bh without an open window has no effect, and prot_o keeps its value.
- R7: Each unlock admits one guarded write only. A second write to 3Bh in the same window is ignored.
- R8: While prot_o[6] is 1, 2^TO_W ticks without a restart cause cpu_rst_o to go to 1 for exactly 2 ticks and wdt_flag_o to be set. While prot_o[6] is 0, no timeout occurs.
- R9: A guarded write with wr_data_i[7]=1 clears the watchdog count to 0, so the next timeout comes a full 2^TO_W ticks after that write.
- R10: Bit 7 of 3Bh always reads as 0. A write of bit 7 to 3Bh without the window does not restart the count.
- R11: A read of 3Ch returns the flag in bit 0, and the flag is 0 from the cycle after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| tick_i | input | 1 | machine-cycle tick enable |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 8 | write address |
| wr_data_i | input | 8 | write data |
| rd_en_i | input | 1 | register read strobe |
| rd_addr_i | input | 8 | read address |
| rd_data_o | output | 8 | read data |
| cpu_rst_o | output | 1 | processor reset request |
| wdt_flag_o | output | 1 | watchdog timeout cause flag |
| prot_o | output | 7 | guarded control bits (bit 6 = watchdog enable) |

## Verification
The assertions check on every cycle that the guarded bits change only in a cycle after a guarded write made while the window was open. They also check that the window opens only after a 55h write to the unlock register, that the flag rises only together with a reset pulse, that the flag falls only after a status read, and that a reset pulse lasts longer than one cycle. Only the bench scenarios can show the exact tick counts: the start-up delay, where the window closes, the full timeout period after a restart, and the two-tick pulse length. The same holds for the cases where a write has no effect, such as a cancelled sequence or an unguarded restart.

// File: rtl/gwdt_pkg.sv
package gwdt_pkg;
  localparam logic [7:0] ADDR_TA   = 8'h3A;
  localparam logic [7:0] ADDR_PROT = 8'h3B;
  localparam logic [7:0] ADDR_STAT = 8'h3C;
  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam int BIT_RESTART = 7;
  localparam int BIT_WDEN    = 6;

  typedef enum logic {UL_IDLE, UL_ARMED} ul_state_e;
  typedef enum logic [1:0] {WD_START, WD_RUN, WD_PULSE} wd_phase_e;
endpackage

// File: rtl/gwdt_unlock.sv
module gwdt_unlock
  import gwdt_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       consume_i,
  output logic       open_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN);

  ul_state_e      state_q;
  logic [CW-1:0]  win_q;
  logic           ta_wr;

  assign ta_wr  = wr_en_i && (wr_addr_i == ADDR_TA);
  assign open_o = (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= UL_IDLE;
      win_q   <= '0;
    end else if (ta_wr) begin
      // any key write restarts or cancels the sequence
      if (wr_data_i == KEY_A) begin
        state_q <= UL_ARMED;
        win_q   <= '0;
      end else if (state_q == UL_ARMED && wr_data_i == KEY_B) begin
        state_q <= UL_IDLE;
        win_q   <= WIN_LOAD;
      end else begin
        state_q <= UL_IDLE;
        win_q   <= '0;
      end
    end else if (consume_i) begin
      win_q <= '0;
    end else if (tick_i && open_o) begin
      win_q <= win_q - 1'b1;
    end
  end
endmodule

// File: rtl/gwdt_core.sv
module gwdt_core
  import gwdt_pkg::*;
#(
  parameter int TO_W        = 17,
  parameter int START_CYC   = 1024,
  parameter int PULSE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic restart_i,
  output logic cpu_rst_o,
  output logic timeout_o
);
  localparam int SW = $clog2(START_CYC + 1);
  localparam int CW = (TO_W > SW) ? TO_W : SW;
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] TO_LAST    = CW'((2 ** TO_W) - 1);
  localparam logic [CW-1:0] START_LAST = CW'(START_CYC - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_TICKS - 1);

  wd_phase_e     phase_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;

  assign timeout_o = (phase_q == WD_RUN) && !restart_i && tick_i && en_i &&
                     (cnt_q == TO_LAST);
  assign cpu_rst_o = (phase_q != WD_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= WD_START;
      cnt_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      case (phase_q)
        WD_START: if (tick_i) begin
          if (cnt_q == START_LAST) begin
            phase_q <= WD_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        WD_RUN: begin
          if (restart_i) begin
            cnt_q <= '0;
          end else if (timeout_o) begin
            phase_q <= WD_PULSE;
            cnt_q   <= '0;
            pcnt_q  <= '0;
          end else if (tick_i && en_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        WD_PULSE: if (tick_i) begin
          if (pcnt_q == PULSE_LAST) phase_q <= WD_RUN;
          else                      pcnt_q  <= pcnt_q + 1'b1;
        end
        default: phase_q <= WD_START;
      endcase
    end
  end
endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt
  import gwdt_pkg::*;
#(
  parameter int         TO_W      = 17,
  parameter int         START_CYC = 1024,
  parameter int         WIN       = 4,
  parameter logic [6:0] PROT_RST  = 7'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       cpu_rst_o,
  output logic       wdt_flag_o,
  output logic [6:0] prot_o
);
  logic       win_open;
  logic       prot_wr;
  logic       accept;
  logic       restart;
  logic       timeout;
  logic       stat_rd;
  logic [6:0] prot_q;
  logic       flag_q;

  assign prot_wr = wr_en_i && (wr_addr_i == ADDR_PROT);
  assign accept  = prot_wr && win_open;
  assign restart = accept && wr_data_i[BIT_RESTART];
  assign stat_rd = rd_en_i && (rd_addr_i == ADDR_STAT);

  gwdt_unlock #(.WIN(WIN)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .consume_i (accept),
    .open_o    (win_open)
  );

  gwdt_core #(.TO_W(TO_W), .START_CYC(START_CYC), .PULSE_TICKS(2)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (prot_q[BIT_WDEN]),
    .restart_i (restart),
    .cpu_rst_o (cpu_rst_o),
    .timeout_o (timeout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= PROT_RST;
      flag_q <= 1'b0;
    end else begin
      if (accept)       prot_q <= wr_data_i[6:0];
      if (timeout)      flag_q <= 1'b1;
      else if (stat_rd) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_PROT: rd_data_o = {1'b0, prot_q};
      ADDR_STAT: rd_data_o = {7'b0, flag_q};
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign prot_o     = prot_q;
  assign wdt_flag_o = flag_q;
endmodule

// File: rtl/gwdt_chk.sv
module gwdt_chk
  import gwdt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       rd_en_i,
  input logic [7:0] rd_addr_i,
  input logic       open_i,
  input logic       cpu_rst_i,
  input logic       flag_i,
  input logic [6:0] prot_i
);
  a_r6_prot_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_i) |-> $past(wr_en_i && wr_addr_i == ADDR_PROT && open_i));

  a_r3_open_after_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_i) |-> $past(wr_en_i && wr_addr_i == ADDR_TA && wr_data_i == KEY_B));

  a_r8_flag_with_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $rose(cpu_rst_i));

  a_r8_pulse_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_i) |=> cpu_rst_i);

  a_r11_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(rd_en_i && rd_addr_i == ADDR_STAT));
endmodule

bind guarded_wdt gwdt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .open_i    (win_open),
  .cpu_rst_i (cpu_rst_o),
  .flag_i    (wdt_flag_o),
  .prot_i    (prot_o)
);

// File: tb/sim_guarded_wdt.sv
module sim_guarded_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int TO_W       = 5;
  localparam int START_CYC  = 8;
  localparam int TIMEOUT    = 2 ** TO_W;
  localparam logic [7:0] A_TA = 8'h3A, A_PROT = 8'h3B, A_STAT = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cpu_rst;
  logic       flag;
  logic [6:0] prot;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  guarded_wdt #(.TO_W(TO_W), .START_CYC(START_CYC), .WIN(4), .PROT_RST(7'h00)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cpu_rst_o(cpu_rst), .wdt_flag_o(flag), .prot_o(prot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock();
    do_wr(A_TA, 8'hAA);
    do_wr(A_TA, 8'h55);
  endtask

  task automatic apply_reset(input bit skip_start);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    if (skip_start) do_tick(START_CYC);
  endtask

  task automatic t_reset_startup();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 cpu_rst in reset", cpu_rst, 1);
    check("R1 prot in reset", prot, 7'h00);
    check("R1 flag in reset", flag, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cpu_rst after release", cpu_rst, 1);
    do_tick(START_CYC - 1);
    check("R2 startup still held", cpu_rst, 1);
    do_tick(1);
    check("R2 startup released", cpu_rst, 0);
  endtask

  task automatic t_unlock();
    logic [7:0] d;
    unlock();
    do_wr(A_PROT, 8'h15);
    check("R3 guarded write taken", prot, 7'h15);
    do_rd(A_PROT, d);
    check("R3 readback", d, 8'h15);
  endtask

  task automatic t_window();
    unlock();
    do_tick(3);
    do_wr(A_PROT, 8'h2A);
    check("R4 write after 3 ticks", prot, 7'h2A);
    unlock();
    do_tick(4);
    do_wr(A_PROT, 8'h11);
    check("R4 write after 4 ticks ignored", prot, 7'h2A);
  endtask

  task automatic t_cancel();
    do_wr(A_TA, 8'hAA);
    do_wr(A_TA, 8'h12);
    do_wr(A_TA, 8'h55);
    do_wr(A_PROT, 8'h33);
    check("R5 cancelled sequence", prot, 7'h2A);
  endtask

  task automatic t_plain();
    do_wr(A_PROT, 8'h0F);
    check("R6 unguarded write ignored", prot, 7'h2A);
  endtask

  task automatic t_once();
    unlock();
    do_wr(A_PROT, 8'h01);
    do_wr(A_PROT, 8'h02);
    check("R7 single write per unlock", prot, 7'h01);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    apply_reset(1'b1);
    unlock();
    do_wr(A_PROT, 8'h40);
    do_tick(TIMEOUT - 1);
    check("R8 no reset before timeout", cpu_rst, 0);
    check("R8 no flag before timeout", flag, 0);
    do_tick(1);
    check("R8 reset at timeout", cpu_rst, 1);
    check("R8 flag at timeout", flag, 1);
    do_tick(1);
    check("R8 pulse tick 2", cpu_rst, 1);
    do_tick(1);
    check("R8 pulse ended", cpu_rst, 0);
    do_rd(A_STAT, d);
    check("R11 read returns flag", d, 8'h01);
    check("R11 flag cleared", flag, 0);
    do_rd(A_STAT, d);
    check("R11 second read", d, 8'h00);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    apply_reset(1'b1);
    unlock();
    do_wr(A_PROT, 8'h40);
    do_tick(20);
    unlock();
    do_wr(A_PROT, 8'hC0);
    do_tick(TIMEOUT - 1);
    check("R9 restart delays timeout", cpu_rst, 0);
    do_tick(1);
    check("R9 timeout after full period", cpu_rst, 1);
    do_rd(A_PROT, d);
    check("R10 restart bit reads 0", d, 8'h40);
  endtask

  task automatic t_plain_restart();
    apply_reset(1'b1);
    unlock();
    do_wr(A_PROT, 8'h40);
    do_tick(20);
    do_wr(A_PROT, 8'hC0);
    do_tick(TIMEOUT - 21);
    check("R10 unguarded restart pre", cpu_rst, 0);
    do_tick(1);
    check("R10 unguarded restart ignored", cpu_rst, 1);
  endtask

  task automatic t_disabled();
    apply_reset(1'b1);
    do_tick(TIMEOUT + 8);
    check("R8 disabled no reset", cpu_rst, 0);
    check("R8 disabled no flag", flag, 0);
  endtask

  initial begin
    t_reset_startup();
    t_unlock();
    t_window();
    t_cancel();
    t_plain();
    t_once();
    t_timeout();
    t_restart();
    t_plain_restart();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule